// File: doc/BRIEF.md
# Event Queue Writer with Generation Bit

This block appends event entries to a circular queue kept in an external memory on behalf of one processor priority. Each accepted event becomes one 32-bit entry: the low 31 bits hold the event number and the top bit holds a generation bit. The generation bit flips every time the write index wraps back to slot 0. A consumer therefore tells fresh entries from stale ones by comparing that bit with its own toggle, and it never needs to read a shared tail pointer.

Event number 0 is reserved to mean "no event" and is never written. Software reports how far it has read by writing its consumer pointer, which is its toggle bit above its slot index. The block raises a full flag when the next write would overwrite an entry that has not been read yet, and it drops events while that flag is high. When notification is enabled, every write also sends a one-cycle notify pulse carrying the queue's priority toward the presentation logic.

Top module: `evq_writer`

## Requirements
- R1: After reset `mem_we`, `ntf_valid` and `q_full` are 0, and the first accepted event is written to slot 0.
- R2: An event is accepted when `ev_valid` is 1, `ev_num` is nonzero and `q_full` is 0. On the clock edge that accepts it, `mem_we` rises for exactly one cycle and `mem_wdata[30:0]` equals the accepted `ev_num`.
- R3: Accepted events are written to consecutive slots, and the slot index wraps from DEPTH-1 to 0 (index AND (DEPTH-1)).
- R4: `mem_wdata[31]` is 1 for writes during the first pass through the queue and inverts on each later pass, so it flips each time the write index returns to 0.
- R5: An event with `ev_num` equal to 0 is ignored: there is no write, no notify, and the slot index does not advance.
- R6: `q_full` is 1 exactly when DEPTH entries are unread, that is when the write and consumer indices are equal and their wrap bits differ. An event offered while `q_full` is 1 produces no write.
- R7: Writing `cons_ptr` with `cons_wr` updates the consumer pointer at that clock edge. `cons_ptr[IDX_W]` is the consumer toggle and `cons_ptr[IDX_W-1:0]` is the next slot to read. `q_full` reflects the new pointer from the next cycle on.
- R8: When `cfg_notify_en` is 1 at acceptance, `ntf_valid` pulses in the same cycle as `mem_we` and `ntf_prio` carries `cfg_prio`. When `cfg_notify_en` is 0, no pulse is sent.
- R9: The event number 2^24, used for inter-processor interrupts, is stored unchanged, as is any other nonzero 31-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered this cycle |
| ev_num | input | 31 | Event number (0 = none) |
| cfg_notify_en | input | 1 | Send a notify pulse on every write |
| cfg_prio | input | PRIO_W | Priority of this queue |
| cons_wr | input | 1 | Consumer pointer update strobe |
| cons_ptr | input | IDX_W+1 | Consumer toggle (MSB) and next slot to read |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | IDX_W | Memory slot index |
| mem_wdata | output | 32 | Entry: generation bit, then event number |
| ntf_valid | output | 1 | Notify pulse |
| ntf_prio | output | PRIO_W | Priority sent with the notify pulse |
| q_full | output | 1 | DEPTH unread entries; events are dropped |

## Verification
The hardest state to reach is a full queue after the write index has already wrapped, where the generation bit and the consumer toggle disagree. In that state a wrong full test or a wrong generation bit looks like either an empty queue or a spurious overwrite. The bench uses a small queue and a reader model that drains only in occasional random bursts, so the writer repeatedly catches up with the reader across several wraps. A directed prelude first fills the queue from empty, offers an event while full, and then frees space through the consumer pointer.

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [30:0]       ev_num,
  input  logic              cfg_notify_en,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cons_wr,
  input  logic [IDX_W:0]    cons_ptr,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              ntf_valid,
  output logic [PRIO_W-1:0] ntf_prio,
  output logic              q_full
);

  logic [IDX_W:0] wr_ptr;
  logic [IDX_W:0] rd_ptr;
  logic           take;

  assign q_full = (wr_ptr[IDX_W-1:0] == rd_ptr[IDX_W-1:0]) &&
                  (wr_ptr[IDX_W] != rd_ptr[IDX_W]);
  assign take   = ev_valid && (ev_num != '0) && !q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ntf_valid <= 1'b0;
      ntf_prio  <= '0;
    end else begin
      mem_we    <= take;
      ntf_valid <= take && cfg_notify_en;
      if (take) begin
        mem_addr  <= wr_ptr[IDX_W-1:0];
        mem_wdata <= {~wr_ptr[IDX_W], ev_num};
        ntf_prio  <= cfg_prio;
        wr_ptr    <= wr_ptr + 1'b1;
      end
      if (cons_wr) rd_ptr <= cons_ptr;
    end
  end

  initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
    else $error("DEPTH must be a power of two of at least 2");

  assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> !mem_we);

  assert_full_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_full) |-> mem_we);

  assert_zero_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_num == '0) |=> !mem_we);

  assert_payload_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[30:0] != '0));

  assert_notify_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> mem_we);

  assert_single_cycle_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !mem_we);

endmodule

// File: tb/tb_evq_writer.sv
module tb_evq_writer;
  localparam int DP = 8;
  localparam int IW = $clog2(DP);
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic [30:0]   ev_num = '0;
  logic          cfg_notify_en = 1'b0;
  logic [PW-1:0] cfg_prio = '0;
  logic          cons_wr = 1'b0;
  logic [IW:0]   cons_ptr = '0;
  logic          mem_we;
  logic [IW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          ntf_valid;
  logic [PW-1:0] ntf_prio;
  logic          q_full;

  evq_writer #(.DEPTH(DP), .PRIO_W(PW)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] bmem [DP];
  logic [30:0] expq [DP];
  logic [IW:0] m_wr = '0;
  logic [IW:0] m_cons = '0;
  logic [IW:0] c_ptr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_full();
    logic [IW:0] d;
    d = m_wr - m_cons;
    return d == (IW+1)'(DP);
  endfunction

  task automatic step(input bit v, input logic [30:0] num, input bit nen,
                      input logic [PW-1:0] pr, input bit cwr, input logic [IW:0] cp);
    bit ef, acc;
    @(negedge clk);
    ev_valid = v; ev_num = num; cfg_notify_en = nen; cfg_prio = pr;
    cons_wr = cwr; cons_ptr = cp;
    ef = model_full();
    #1;
    chk(q_full == ef, "R6 full flag", 32'(q_full), 32'(ef));
    acc = v && (num != 0) && !ef;
    @(posedge clk);
    #1;
    chk(mem_we == acc, (num == 0) ? "R5 zero event write" : "R2 write enable",
        32'(mem_we), 32'(acc));
    if (acc && mem_we) begin
      chk(mem_addr == m_wr[IW-1:0], "R3 slot index", 32'(mem_addr), 32'(m_wr[IW-1:0]));
      chk(mem_wdata[31] == ~m_wr[IW], "R4 generation bit", 32'(mem_wdata[31]), 32'(~m_wr[IW]));
      chk(mem_wdata[30:0] == num, "R2 event number", 32'(mem_wdata[30:0]), 32'(num));
      chk(ntf_valid == nen, "R8 notify pulse", 32'(ntf_valid), 32'(nen));
      if (nen) chk(ntf_prio == pr, "R8 notify priority", 32'(ntf_prio), 32'(pr));
      bmem[mem_addr] = mem_wdata;
      expq[m_wr[IW-1:0]] = num;
      m_wr = m_wr + 1'b1;
    end else begin
      chk(ntf_valid == 1'b0, "R8 no notify without write", 32'(ntf_valid), 32'd0);
    end
    if (cwr) m_cons = cp;
    ev_valid = 1'b0; cons_wr = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) begin
      bit seen, exp_seen;
      seen = bmem[c_ptr[IW-1:0]][31] != c_ptr[IW];
      exp_seen = (m_wr != c_ptr);
      chk(seen == exp_seen, "R4 reader validity", 32'(seen), 32'(exp_seen));
      if (!seen) break;
      chk(bmem[c_ptr[IW-1:0]][30:0] == expq[c_ptr[IW-1:0]], "R2 reader payload",
          32'(bmem[c_ptr[IW-1:0]][30:0]), 32'(expq[c_ptr[IW-1:0]]));
      c_ptr = c_ptr + 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DP; i++) bmem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(mem_we == 1'b0, "R1 reset mem_we", 32'(mem_we), 32'd0);
    chk(ntf_valid == 1'b0, "R1 reset notify", 32'(ntf_valid), 32'd0);
    chk(q_full == 1'b0, "R1 reset full", 32'(q_full), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 31'd5, 1, 3'd3, 0, '0);
    chk(mem_addr == '0, "R1 first slot", 32'(mem_addr), 32'd0);
    step(1, 31'd0, 1, 3'd2, 0, '0);
    step(1, 31'h0100_0000, 1, 3'd1, 0, '0);
    chk(mem_wdata == 32'h8100_0000, "R9 IPI number stored", mem_wdata, 32'h8100_0000);
    while (!model_full()) step(1, 31'(m_wr) + 31'd40, 0, 3'd0, 0, '0);
    step(1, 31'd77, 1, 3'd4, 0, '0);
    #1;
    chk(q_full == 1'b1, "R6 stays full after drop", 32'(q_full), 32'd1);
    drain(3);
    step(0, 31'd0, 0, 3'd0, 1, c_ptr);
    @(negedge clk);
    chk(q_full == 1'b0, "R7 full clears after consumer update", 32'(q_full), 32'd0);
    step(1, 31'd99, 0, 3'd6, 0, '0);
    step(1, 31'h7fff_ffff, 1, 3'd7, 0, '0);

    for (int n = 0; n < 4000; n++) begin
      bit v, cw;
      logic [30:0] num;
      v = ($urandom % 10) < 7;
      case ($urandom % 10)
        0: num = '0;
        1: num = 31'h0100_0000;
        default: num = 31'($urandom);
      endcase
      cw = ($urandom % 8) == 0;
      if (cw) drain($urandom % (DP + 1));
      step(v, num, ($urandom % 4) != 0, PW'($urandom), cw, c_ptr);
    end
    drain(DP + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule